// File: doc/BRIEF.md
# Set-Associative Translation Cache with Access Check

This block keeps a small number of page table entries close to the address path of a memory management unit. A lookup presents a virtual address, an access kind and the current privilege mode. Within the same cycle the block returns either a hit with the physical address and a protection verdict, or a miss. The physical address is formed from the stored frame number and the untouched page offset. A lookup that hits needs no memory access. A lookup that misses tells the page walker to fetch the entry, which costs one extra memory access.

The walker returns the entry on a refill port. The refill writes it into one way of the set chosen by the low bits of the page number. An empty way is used first. When the set is full, the least recently used way is replaced. A single-cycle flush input empties the whole structure. The default geometry is 16 sets of 4 ways, with 20-bit virtual and physical page numbers and a 12-bit page offset.

Top module: `xlat_cache`

## Requirements
- R1: The set is selected by the low log2(SETS) bits of the page number (virtual address bits [OFF_W+SET_W-1:OFF_W]), and the remaining upper page bits form the tag. A hit needs a valid way in that set whose tag is equal. Up to WAYS entries that share an index but differ in tag are all held at the same time.
- R2: A hit is reported combinationally, in the same cycle as `lk_valid_i`. `lk_paddr_o` is then {stored frame number, lk_vaddr_i[OFF_W-1:0]}, so the offset passes through unchanged.
- R3: A lookup with no matching valid entry raises `lk_miss_o`, with `lk_paddr_o` equal to zero. While `lk_valid_i` is low, hit, miss and fault all stay low.
- R4: The permission field is {sup[3], exec[2], write[1], read[0]}. The access code on `lk_acc_i` is 0 for read, 1 for write, 2 for execute and 3 reserved. On a hit, `lk_fault_o` is raised when the matching permission bit is clear or the code is 3. A miss never faults.
- R5: On a hit to an entry whose sup bit is set, `lk_fault_o` is raised when `lk_sup_i` is low, whatever the access kind.
- R6: A refill into a set that still has an empty way writes that empty way and evicts no valid entry. This also holds after a flush, whatever the earlier usage order was.
- R7: A refill into a full set replaces the least recently used way. Both hits (faulting or not) and refills count as a use.
- R8: While `flush_i` is high, every entry becomes invalid at the next edge, a lookup in the same cycle misses, and a refill in the same cycle is discarded.
- R9: When a refill and a lookup name the same set in one cycle, the refill is written and the lookup reports a miss. When they name different sets, both take effect.
- R10: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | VPN_W+OFF_W | Virtual address of the lookup |
| lk_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_sup_i | input | 1 | Lookup issued in supervisor mode |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | No translation; walker must fetch the entry |
| lk_fault_o | output | 1 | Hit whose permissions deny the access |
| lk_paddr_o | output | PPN_W+OFF_W | Translated physical address, zero when not hit |
| rf_valid_i | input | 1 | Refill write request |
| rf_vpn_i | input | VPN_W | Page number of the refilled entry |
| rf_ppn_i | input | PPN_W | Frame number of the refilled entry |
| rf_perm_i | input | 4 | Permission field {sup, exec, write, read} |

## Verification
Three functions can fall into one cycle: a lookup, a refill and a flush. The bench drives a lookup and a refill to the same set in one cycle and expects a miss. It then expects both the old entry and the refilled one to hit. It repeats the pair on different sets and expects the lookup to hit at once. It raises flush alongside a lookup and alongside a refill, and in both cases judges by later lookups that nothing survived or was written.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic sup;
    logic exe;
    logic wr;
    logic rd;
  } perm_t;

  localparam int unsigned PERM_W = $bits(perm_t);
endpackage

// File: rtl/xlat_entry_array.sv
module xlat_entry_array #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned PRM_W = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic [PRM_W-1:0] wr_perm_i,
  input  logic [SET_W-1:0] rd_set_i,
  output logic [WAYS-1:0]  rd_vld_o,
  output logic [TAG_W-1:0] rd_tag_o  [WAYS],
  output logic [PPN_W-1:0] rd_ppn_o  [WAYS],
  output logic [PRM_W-1:0] rd_perm_o [WAYS],
  input  logic [SET_W-1:0] fill_set_i,
  output logic [WAYS-1:0]  fill_vld_o
);
  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q  [SETS][WAYS];
  logic [PRM_W-1:0] perm_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_set_i][wr_way_i] <= 1'b1;
    end
  end

  // payload needs no reset: guarded by valid bits
  always_ff @(posedge clk_i) begin
    if (wr_en_i && !flush_i) begin
      tag_q[wr_set_i][wr_way_i]  <= wr_tag_i;
      ppn_q[wr_set_i][wr_way_i]  <= wr_ppn_i;
      perm_q[wr_set_i][wr_way_i] <= wr_perm_i;
    end
  end

  always_comb begin
    rd_vld_o   = vld_q[rd_set_i];
    fill_vld_o = vld_q[fill_set_i];
    for (int w = 0; w < WAYS; w++) begin
      rd_tag_o[w]  = tag_q[rd_set_i][w];
      rd_ppn_o[w]  = ppn_q[rd_set_i][w];
      rd_perm_o[w] = perm_q[rd_set_i][w];
    end
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_en_i,
  input  logic [SET_W-1:0] hit_set_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             fill_en_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic [SET_W-1:0] q_set_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [SETS-1:0][WAY_W-1:0] victim_all;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    // rank 0 = most recent, WAYS-1 = least recent
    logic [WAY_W-1:0] rank_q [WAYS];
    logic             touch;
    logic [WAY_W-1:0] tway;
    logic [WAY_W-1:0] vic;

    always_comb begin
      touch = 1'b0;
      tway  = '0;
      if (fill_en_i && fill_set_i == SET_W'(s)) begin
        touch = 1'b1;
        tway  = fill_way_i;
      end else if (hit_en_i && hit_set_i == SET_W'(s)) begin
        touch = 1'b1;
        tway  = hit_way_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < WAYS; w++) rank_q[w] <= WAY_W'(w);
      end else if (touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == tway)           rank_q[w] <= '0;
          else if (rank_q[w] < rank_q[tway]) rank_q[w] <= rank_q[w] + 1'b1;
        end
      end
    end

    always_comb begin
      vic = '0;
      for (int w = 0; w < WAYS; w++)
        if (rank_q[w] == WAY_W'(WAYS - 1)) vic = WAY_W'(w);
    end

    assign victim_all[s] = vic;
  end

  assign victim_o = victim_all[q_set_i];
endmodule

// File: rtl/xlat_perm_chk.sv
module xlat_perm_chk
  import xlat_pkg::*;
(
  input  perm_t      perm_i,
  input  logic [1:0] acc_i,
  input  logic       sup_i,
  output logic       fault_o
);
  logic deny;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  deny = !perm_i.rd;
      ACC_WRITE: deny = !perm_i.wr;
      ACC_EXEC:  deny = !perm_i.exe;
      default:   deny = 1'b1;
    endcase
  end

  assign fault_o = deny | (perm_i.sup & ~sup_i);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned VA_W = VPN_W + OFF_W,
  localparam int unsigned PA_W = PPN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [1:0]        lk_acc_i,
  input  logic              lk_sup_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_fault_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  input  logic              rf_valid_i,
  input  logic [VPN_W-1:0]  rf_vpn_i,
  input  logic [PPN_W-1:0]  rf_ppn_i,
  input  logic [PERM_W-1:0] rf_perm_i
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned TAG_W = VPN_W - SET_W;

  logic [VPN_W-1:0]  lk_vpn;
  logic [SET_W-1:0]  lk_set, rf_set;
  logic [TAG_W-1:0]  lk_tag, rf_tag;

  assign lk_vpn = lk_vaddr_i[VA_W-1:OFF_W];
  assign lk_set = lk_vpn[SET_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:SET_W];
  assign rf_set = rf_vpn_i[SET_W-1:0];
  assign rf_tag = rf_vpn_i[VPN_W-1:SET_W];

  logic [WAYS-1:0]   rd_vld, fill_vld;
  logic [TAG_W-1:0]  rd_tag  [WAYS];
  logic [PPN_W-1:0]  rd_ppn  [WAYS];
  logic [PERM_W-1:0] rd_perm [WAYS];
  logic              wr_en;
  logic [WAY_W-1:0]  fill_way, lru_victim;

  assign wr_en = rf_valid_i & ~flush_i;

  xlat_entry_array #(
    .SETS (SETS), .WAYS (WAYS), .TAG_W (TAG_W), .PPN_W (PPN_W), .PRM_W (PERM_W)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .wr_en_i    (wr_en),
    .wr_set_i   (rf_set),
    .wr_way_i   (fill_way),
    .wr_tag_i   (rf_tag),
    .wr_ppn_i   (rf_ppn_i),
    .wr_perm_i  (rf_perm_i),
    .rd_set_i   (lk_set),
    .rd_vld_o   (rd_vld),
    .rd_tag_o   (rd_tag),
    .rd_ppn_o   (rd_ppn),
    .rd_perm_o  (rd_perm),
    .fill_set_i (rf_set),
    .fill_vld_o (fill_vld)
  );

  // tag compare per way
  logic [WAYS-1:0] match;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = rd_vld[w] & (rd_tag[w] == lk_tag);
  end

  logic [PPN_W-1:0]  hit_ppn;
  logic [PERM_W-1:0] hit_perm;
  logic [WAY_W-1:0]  hit_way;

  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    hit_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        hit_ppn  = hit_ppn  | rd_ppn[w];
        hit_perm = hit_perm | rd_perm[w];
        hit_way  = hit_way  | WAY_W'(w);
      end
    end
  end

  // flush or same-set refill turns the lookup into a miss
  logic blocked;
  assign blocked = flush_i | (rf_valid_i & (rf_set == lk_set));

  logic perm_fault;
  xlat_perm_chk u_perm (
    .perm_i  (perm_t'(hit_perm)),
    .acc_i   (lk_acc_i),
    .sup_i   (lk_sup_i),
    .fault_o (perm_fault)
  );

  assign lk_hit_o   = lk_valid_i & (|match) & ~blocked;
  assign lk_miss_o  = lk_valid_i & ~lk_hit_o;
  assign lk_fault_o = lk_hit_o & perm_fault;
  assign lk_paddr_o = lk_hit_o ? {hit_ppn, lk_vaddr_i[OFF_W-1:0]} : '0;

  // victim: lowest empty way, else least recently used
  logic             have_free;
  logic [WAY_W-1:0] free_way;
  always_comb begin
    have_free = 1'b0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!fill_vld[w]) begin
        have_free = 1'b1;
        free_way  = WAY_W'(w);
      end
    end
  end
  assign fill_way = have_free ? free_way : lru_victim;

  xlat_lru #(
    .SETS (SETS), .WAYS (WAYS)
  ) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_en_i   (lk_hit_o),
    .hit_set_i  (lk_set),
    .hit_way_i  (hit_way),
    .fill_en_i  (wr_en),
    .fill_set_i (rf_set),
    .fill_way_i (fill_way),
    .q_set_i    (rf_set),
    .victim_o   (lru_victim)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   flush_i,
  input logic                   lk_valid_i,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr_i,
  input logic                   lk_hit_o,
  input logic                   lk_miss_o,
  input logic                   lk_fault_o,
  input logic [PPN_W+OFF_W-1:0] lk_paddr_o,
  input logic                   rf_valid_i,
  input logic [VPN_W-1:0]       rf_vpn_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(lk_hit_o || lk_miss_o || lk_fault_o)); // R3

  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_paddr_o[OFF_W-1:0] == lk_vaddr_i[OFF_W-1:0]); // R2

  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o); // R4

  AST_FLUSH_SAME_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && flush_i |-> lk_miss_o); // R8

  AST_FLUSH_NEXT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lk_hit_o); // R8

  AST_COLLIDE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && rf_valid_i &&
    lk_vaddr_i[OFF_W+SET_W-1:OFF_W] == rf_vpn_i[SET_W-1:0] |-> lk_miss_o); // R9
endmodule

bind xlat_cache xlat_cache_chk #(
  .SETS (SETS), .VPN_W (VPN_W), .PPN_W (PPN_W), .OFF_W (OFF_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flush_i    (flush_i),
  .lk_valid_i (lk_valid_i),
  .lk_vaddr_i (lk_vaddr_i),
  .lk_hit_o   (lk_hit_o),
  .lk_miss_o  (lk_miss_o),
  .lk_fault_o (lk_fault_o),
  .lk_paddr_o (lk_paddr_o),
  .rf_valid_i (rf_valid_i),
  .rf_vpn_i   (rf_vpn_i)
);

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_acc;
  logic        lk_sup;
  logic        hit, miss, fault;
  logic [31:0] paddr;
  logic        rf_valid;
  logic [19:0] rf_vpn, rf_ppn;
  logic [3:0]  rf_perm;

  int n_chk = 0;
  int n_err = 0;
  logic        s_hit, s_miss, s_fault;
  logic [31:0] s_pa;

  always #5 clk = ~clk;

  xlat_cache u_dut (
    .clk_i (clk), .rst_ni (rst_n), .flush_i (flush),
    .lk_valid_i (lk_valid), .lk_vaddr_i (lk_vaddr), .lk_acc_i (lk_acc), .lk_sup_i (lk_sup),
    .lk_hit_o (hit), .lk_miss_o (miss), .lk_fault_o (fault), .lk_paddr_o (paddr),
    .rf_valid_i (rf_valid), .rf_vpn_i (rf_vpn), .rf_ppn_i (rf_ppn), .rf_perm_i (rf_perm)
  );

  function automatic logic [19:0] ppn_of(input logic [19:0] v);
    return (v * 20'd7 + 20'h3C1) ^ 20'h5A5A5;
  endfunction

  function automatic logic [19:0] mk(input logic [15:0] tag, input logic [3:0] set);
    return {tag, set};
  endfunction

  function automatic logic exp_fault(input logic [3:0] p, input logic [1:0] acc, input logic sup);
    logic d;
    case (acc)
      2'd0: d = !p[0];
      2'd1: d = !p[1];
      2'd2: d = !p[2];
      default: d = 1'b1;
    endcase
    return d | (p[3] & !sup);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic both(input logic lv, input logic [19:0] lvpn, input logic [11:0] off,
                      input logic [1:0] acc, input logic sup,
                      input logic rv, input logic [19:0] rvpn, input logic [3:0] perm,
                      input logic fl);
    @(negedge clk);
    lk_valid = lv; lk_vaddr = {lvpn, off}; lk_acc = acc; lk_sup = sup;
    rf_valid = rv; rf_vpn = rvpn; rf_ppn = ppn_of(rvpn); rf_perm = perm;
    flush = fl;
    #1;
    s_hit = hit; s_miss = miss; s_fault = fault; s_pa = paddr;
    @(posedge clk);
    #1;
    lk_valid = 1'b0; rf_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off,
                      input logic [1:0] acc, input logic sup);
    both(1'b1, vpn, off, acc, sup, 1'b0, 20'd0, 4'd0, 1'b0);
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [3:0] perm);
    both(1'b0, 20'd0, 12'd0, 2'd0, 1'b0, 1'b1, vpn, perm, 1'b0);
  endtask

  task automatic do_flush();
    both(1'b0, 20'd0, 12'd0, 2'd0, 1'b0, 1'b0, 20'd0, 4'd0, 1'b1);
  endtask

  task automatic exp_hit(input logic [19:0] vpn, input logic [11:0] off, input string req);
    logic [31:0] e;
    look(vpn, off, 2'd0, 1'b0);
    e = {ppn_of(vpn), off};
    chk(s_hit && !s_miss && s_pa == e, req, {s_hit, s_pa}, {1'b1, e});
  endtask

  task automatic exp_miss(input logic [19:0] vpn, input string req);
    look(vpn, 12'h123, 2'd0, 1'b0);
    chk(!s_hit && s_miss && !s_fault && s_pa == 32'd0, req, {s_hit, s_miss, s_pa}, {2'b01, 32'd0});
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_acc = '0; lk_sup = 1'b0;
    rf_valid = 1'b0; rf_vpn = '0; rf_ppn = '0; rf_perm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: empty after reset
    exp_miss(mk(16'h0100, 4'd0), "R10");
    exp_miss(mk(16'h0211, 4'd7), "R10");
    exp_miss(mk(16'hFFFF, 4'd15), "R10");

    // R1 R6: four tags per set all resident
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        refill(mk(16'h0100 + 16'(w) * 16'h0111 + 16'(s), 4'(s)), 4'b0111);
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        exp_hit(mk(16'h0100 + 16'(w) * 16'h0111 + 16'(s), 4'(s)),
                12'((s * 37 + w * 11) % 4096), "R1_R2");

    // R3: unknown tag, and idle outputs
    exp_miss(mk(16'hBEEF, 4'd3), "R3");
    @(negedge clk); #1;
    chk(!hit && !miss && !fault, "R3", {hit, miss, fault}, 3'b000);

    // R4 R5: every permission value against every access kind and mode
    do_flush();
    for (int p = 0; p < 16; p++) refill(mk(16'h2000 + 16'(p), 4'(p)), 4'(p));
    for (int p = 0; p < 16; p++)
      for (int a = 0; a < 4; a++)
        for (int m = 0; m < 2; m++) begin
          logic ef;
          look(mk(16'h2000 + 16'(p), 4'(p)), 12'h0AB, 2'(a), 1'(m));
          ef = exp_fault(4'(p), 2'(a), 1'(m));
          chk(s_hit && s_fault == ef, "R4_R5", {s_hit, s_fault}, {1'b1, ef});
        end

    // R6 R7: after flush, stale order ignored; then true LRU replacement in set 5
    do_flush();
    refill(mk(16'h3001, 4'd5), 4'b0001);
    refill(mk(16'h3002, 4'd5), 4'b0001);
    refill(mk(16'h3003, 4'd5), 4'b0001);
    refill(mk(16'h3004, 4'd5), 4'b0001);
    exp_hit(mk(16'h3001, 4'd5), 12'h010, "R6");
    exp_hit(mk(16'h3002, 4'd5), 12'h020, "R6");
    exp_hit(mk(16'h3003, 4'd5), 12'h030, "R6");
    exp_hit(mk(16'h3004, 4'd5), 12'h040, "R6");
    exp_hit(mk(16'h3001, 4'd5), 12'h050, "R7");
    exp_hit(mk(16'h3003, 4'd5), 12'h060, "R7");
    refill(mk(16'h3005, 4'd5), 4'b0001);          // evicts 3002
    exp_miss(mk(16'h3002, 4'd5), "R7");
    exp_hit(mk(16'h3001, 4'd5), 12'h070, "R7");
    exp_hit(mk(16'h3003, 4'd5), 12'h080, "R7");
    exp_hit(mk(16'h3004, 4'd5), 12'h090, "R7");
    exp_hit(mk(16'h3005, 4'd5), 12'h0A0, "R7");
    refill(mk(16'h3006, 4'd5), 4'b0001);          // evicts 3001
    exp_miss(mk(16'h3001, 4'd5), "R7");
    exp_hit(mk(16'h3003, 4'd5), 12'h0B0, "R7");
    exp_hit(mk(16'h3006, 4'd5), 12'h0C0, "R7");

    // R8: flush with lookup, then entries gone; refill with flush dropped
    both(1'b1, mk(16'h3005, 4'd5), 12'h001, 2'd0, 1'b0, 1'b0, 20'd0, 4'd0, 1'b1);
    chk(!s_hit && s_miss, "R8", {s_hit, s_miss}, 2'b01);
    exp_miss(mk(16'h3003, 4'd5), "R8");
    both(1'b0, 20'd0, 12'd0, 2'd0, 1'b0, 1'b1, mk(16'h3007, 4'd6), 4'b0001, 1'b1);
    exp_miss(mk(16'h3007, 4'd6), "R8");

    // R9: same-set collision, then different-set pair
    refill(mk(16'h4001, 4'd9), 4'b0001);
    both(1'b1, mk(16'h4001, 4'd9), 12'h222, 2'd0, 1'b0, 1'b1, mk(16'h4002, 4'd9), 4'b0001, 1'b0);
    chk(!s_hit && s_miss, "R9", {s_hit, s_miss}, 2'b01);
    exp_hit(mk(16'h4001, 4'd9), 12'h333, "R9");
    exp_hit(mk(16'h4002, 4'd9), 12'h444, "R9");
    both(1'b1, mk(16'h4001, 4'd9), 12'h555, 2'd0, 1'b0, 1'b1, mk(16'h4003, 4'd10), 4'b0001, 1'b0);
    chk(s_hit && s_pa == {ppn_of(mk(16'h4001, 4'd9)), 12'h555}, "R9", s_pa,
        {ppn_of(mk(16'h4001, 4'd9)), 12'h555});
    exp_hit(mk(16'h4003, 4'd10), 12'h666, "R9");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule